// File: doc/BRIEF.md
# Dual-Bank Flash Address Remap and Access Guard

This block sits between the bus masters and a dual-bank flash array. It turns a logical flash address into a physical bank select and an in-bank offset. A single swap bit decides which physical bank answers the lower logical window. The same block checks each access against a set of privilege rules before the access can reach the array. Under these rules the lower logical bank is the one that runs code: it accepts data reads and instruction fetches and refuses program and erase. The upper logical bank accepts reads, program and erase and refuses fetches. Two sets of sector-bounded regions add finer rules on top. A full-protect region blocks both reads and fetches. A hidden-code region blocks data reads but still lets instructions be fetched.

Each logical bank spans 2^BANK_AW bytes, which is 256 KiB at the defaults. Logical bank 0 starts at address zero and logical bank 1 follows it directly. Addresses above the two windows are refused. Requests from the CPU, the DMA or the debugger go through the same checks, and the requester tag is only carried through to the response. Each request presented with `acc_valid` gives one registered response in the next cycle. A refused response never raises `rsp_go`, the strobe that lets the array act, and it reports zeros for the bank and offset.

Top module: `flash_bank_guard`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `rsp_valid` and `rsp_go` are 0. The swap bit is cleared, so logical bank 0 maps to physical bank 0 even if the swap bit was set before the reset.
- R2: For an accepted access, `rsp_bank` equals address bit BANK_AW XOR the swap bit. `rsp_offset` equals the low BANK_AW address bits.
- R3: A pulse on `swap_set_en` loads `swap_set_val` into the swap bit at that clock edge. An access sampled at the same edge still uses the old value. Accesses from the next cycle onward use the new value.
- R4: An address with any bit at or above position BANK_AW+1 set is refused with cause 1, whatever the access type.
- R5: Program (type 2) and erase (type 3) to logical bank 0 are refused with cause 2.
- R6: An instruction fetch (type 1) to logical bank 1 is refused with cause 3.
- R7: A full-protect region hits when it is enabled and the sector index, address bits [BANK_AW:SECTOR_AW], lies within its inclusive start and end bounds. A hit refuses data reads (type 0) and fetches with cause 4, and has no effect on program or erase. A disabled region, or one whose start is greater than its end, never hits.
- R8: A hidden-code region, matched in the same way, refuses data reads with cause 5 and lets fetches through.
- R9: Causes are checked in the order R4, R5/R6, R7, R8. Where the two region kinds overlap, the full-protect rule wins.
- R10: `acc_master` has no effect on the decision. It comes back unchanged on `rsp_master`.
- R11: `rsp_go` is 1 exactly when the response is valid and `rsp_err` is 0, in which case `rsp_cause` is 0. When `rsp_err` is 1, `rsp_bank` and `rsp_offset` are 0.
- R12: `rsp_valid` follows `acc_valid` with one cycle of delay. A cycle with no request gives a response with `rsp_valid`, `rsp_go` and `rsp_err` all at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| swap_set_en | input | 1 | Load strobe for the swap bit |
| swap_set_val | input | 1 | New swap bit value |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | ADDR_W | Logical byte address |
| acc_type | input | 2 | 0 data read, 1 instruction fetch, 2 program, 3 erase |
| acc_master | input | MST_W | Requester tag (CPU, DMA, debugger) |
| rxp_en | input | NUM_RXP | Enable per full-protect region |
| rxp_lo | input | NUM_RXP*SEC_W | Start sector for each full-protect region |
| rxp_hi | input | NUM_RXP*SEC_W | End sector for each full-protect region |
| ipp_en | input | NUM_IPP | Enable per hidden-code region |
| ipp_lo | input | NUM_IPP*SEC_W | Start sector for each hidden-code region |
| ipp_hi | input | NUM_IPP*SEC_W | End sector for each hidden-code region |
| rsp_valid | output | 1 | Response present |
| rsp_go | output | 1 | Access granted to the array |
| rsp_err | output | 1 | Access refused |
| rsp_cause | output | 3 | 0 ok, 1 range, 2 write to code bank, 3 fetch from data bank, 4 full-protect, 5 hidden-code |
| rsp_bank | output | 1 | Physical bank select |
| rsp_offset | output | BANK_AW | Byte offset within the physical bank |
| rsp_master | output | MST_W | Echoed requester tag |

## Verification
The main test sweeps every sector of both logical banks with each of the four access types, once with the swap bit clear and once with it set. This shows that the bank select follows the swap bit and that the code and data privileges move together with it. The sweep is repeated with all regions disabled, which separates the bank-level rules from the region rules. The region layout includes an overlap, an inverted-bounds region and a hidden-code window inside the code bank, so the strictest-rule order and the fetch exemption can both be seen. Separate cases cover out-of-window addresses, a swap write in the same cycle as an access, a reset while the swap bit is set, idle cycles, and the same address issued under each master tag.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_FETCH = 2'd1,
    ACC_PROG  = 2'd2,
    ACC_ERASE = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    CAUSE_NONE       = 3'd0,
    CAUSE_RANGE      = 3'd1,
    CAUSE_EXEC_WRITE = 3'd2,
    CAUSE_DATA_FETCH = 3'd3,
    CAUSE_FULL_PROT  = 3'd4,
    CAUSE_HIDDEN     = 3'd5
  } cause_e;

  typedef struct packed {
    logic in_range;
    logic lbank;
    logic full_hit;
    logic hidden_hit;
  } access_flags_t;

endpackage

// File: rtl/fbg_bank_map.sv
module fbg_bank_map #(
  parameter int ADDR_W  = 32,
  parameter int BANK_AW = 18
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               swap,
  output logic               in_range,
  output logic               lbank,
  output logic               pbank,
  output logic [BANK_AW-1:0] offset
);
  localparam int HI_W = ADDR_W - BANK_AW - 1;

  // Anything above the two logical windows is out of range
  assign in_range = (addr[ADDR_W-1 -: HI_W] == '0);
  assign lbank    = addr[BANK_AW];
  assign pbank    = addr[BANK_AW] ^ swap;
  assign offset   = addr[BANK_AW-1:0];
endmodule

// File: rtl/fbg_region_match.sv
module fbg_region_match #(
  parameter int NUM   = 2,
  parameter int SEC_W = 9
) (
  input  logic [SEC_W-1:0]     sector,
  input  logic [NUM-1:0]       en,
  input  logic [NUM*SEC_W-1:0] lo_flat,
  input  logic [NUM*SEC_W-1:0] hi_flat,
  output logic                 hit
);
  logic [NUM-1:0] per_region;

  generate
    for (genvar g = 0; g < NUM; g++) begin : g_rgn
      logic [SEC_W-1:0] lo, hi;
      assign lo = lo_flat[g*SEC_W +: SEC_W];
      assign hi = hi_flat[g*SEC_W +: SEC_W];
      // Inclusive bounds; lo > hi can never match
      assign per_region[g] = en[g] && (sector >= lo) && (sector <= hi);
    end
  endgenerate

  assign hit = |per_region;
endmodule

// File: rtl/fbg_policy.sv
module fbg_policy
  import fbg_pkg::*;
(
  input  acc_kind_e     kind,
  input  access_flags_t flags,
  output cause_e        cause
);
  logic is_write, is_fetch, is_read;

  assign is_write = (kind == ACC_PROG) || (kind == ACC_ERASE);
  assign is_fetch = (kind == ACC_FETCH);
  assign is_read  = (kind == ACC_READ);

  // Strictest rule first: range, bank privilege, full protect, hidden code
  always_comb begin
    if (!flags.in_range)                      cause = CAUSE_RANGE;
    else if (!flags.lbank && is_write)        cause = CAUSE_EXEC_WRITE;
    else if (flags.lbank && is_fetch)         cause = CAUSE_DATA_FETCH;
    else if (flags.full_hit && !is_write)     cause = CAUSE_FULL_PROT;
    else if (flags.hidden_hit && is_read)     cause = CAUSE_HIDDEN;
    else                                      cause = CAUSE_NONE;
  end
endmodule

// File: rtl/flash_bank_guard.sv
module flash_bank_guard
  import fbg_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BANK_AW   = 18,
  parameter int SECTOR_AW = 10,
  parameter int NUM_RXP   = 2,
  parameter int NUM_IPP   = 2,
  parameter int MST_W     = 2,
  localparam int SEC_W    = BANK_AW + 1 - SECTOR_AW
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     swap_set_en,
  input  logic                     swap_set_val,
  input  logic                     acc_valid,
  input  logic [ADDR_W-1:0]        acc_addr,
  input  logic [1:0]               acc_type,
  input  logic [MST_W-1:0]         acc_master,
  input  logic [NUM_RXP-1:0]       rxp_en,
  input  logic [NUM_RXP*SEC_W-1:0] rxp_lo,
  input  logic [NUM_RXP*SEC_W-1:0] rxp_hi,
  input  logic [NUM_IPP-1:0]       ipp_en,
  input  logic [NUM_IPP*SEC_W-1:0] ipp_lo,
  input  logic [NUM_IPP*SEC_W-1:0] ipp_hi,
  output logic                     rsp_valid,
  output logic                     rsp_go,
  output logic                     rsp_err,
  output logic [2:0]               rsp_cause,
  output logic                     rsp_bank,
  output logic [BANK_AW-1:0]       rsp_offset,
  output logic [MST_W-1:0]         rsp_master
);
  logic               swap_q;
  logic               in_range, lbank, pbank;
  logic [BANK_AW-1:0] offset;
  logic [SEC_W-1:0]   sector;
  logic               full_hit, hidden_hit;
  access_flags_t      flags;
  cause_e             cause;
  logic               grant;

  assign sector = acc_addr[BANK_AW:SECTOR_AW];

  fbg_bank_map #(.ADDR_W(ADDR_W), .BANK_AW(BANK_AW)) map_i (
    .addr(acc_addr), .swap(swap_q), .in_range(in_range),
    .lbank(lbank), .pbank(pbank), .offset(offset)
  );

  fbg_region_match #(.NUM(NUM_RXP), .SEC_W(SEC_W)) full_i (
    .sector(sector), .en(rxp_en), .lo_flat(rxp_lo), .hi_flat(rxp_hi), .hit(full_hit)
  );

  fbg_region_match #(.NUM(NUM_IPP), .SEC_W(SEC_W)) hidden_i (
    .sector(sector), .en(ipp_en), .lo_flat(ipp_lo), .hi_flat(ipp_hi), .hit(hidden_hit)
  );

  assign flags = '{in_range: in_range, lbank: lbank, full_hit: full_hit, hidden_hit: hidden_hit};

  fbg_policy policy_i (
    .kind(acc_kind_e'(acc_type)), .flags(flags), .cause(cause)
  );

  assign grant = (cause == CAUSE_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      swap_q     <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_go     <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_cause  <= 3'd0;
      rsp_bank   <= 1'b0;
      rsp_offset <= '0;
      rsp_master <= '0;
    end else begin
      if (swap_set_en) swap_q <= swap_set_val;
      rsp_valid  <= acc_valid;
      rsp_go     <= acc_valid && grant;
      rsp_err    <= acc_valid && !grant;
      rsp_cause  <= acc_valid ? cause : CAUSE_NONE;
      rsp_bank   <= (acc_valid && grant) ? pbank : 1'b0;
      rsp_offset <= (acc_valid && grant) ? offset : '0;
      rsp_master <= acc_valid ? acc_master : '0;
    end
  end
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int ADDR_W  = 32,
  parameter int BANK_AW = 18
) (
  input logic               clk,
  input logic               rst,
  input logic               swap_set_en,
  input logic               swap_set_val,
  input logic               swap_q,
  input logic               acc_valid,
  input logic [ADDR_W-1:0]  acc_addr,
  input logic [1:0]         acc_type,
  input logic               rsp_valid,
  input logic               rsp_go,
  input logic               rsp_err,
  input logic [2:0]         rsp_cause,
  input logic               rsp_bank,
  input logic [BANK_AW-1:0] rsp_offset
);
  logic in_win;
  assign in_win = ((acc_addr >> (BANK_AW + 1)) == '0);

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && !rsp_go && !swap_q));

  a_r3_swap_load: assert property (@(posedge clk) disable iff (rst)
    swap_set_en |=> (swap_q == $past(swap_set_val)));

  a_r3_swap_hold: assert property (@(posedge clk) disable iff (rst)
    !swap_set_en |=> $stable(swap_q));

  a_r2_bank_map: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && in_win && (acc_type == 2'd0) && !acc_addr[BANK_AW]) |=>
      (!rsp_go || (rsp_bank == $past(swap_q) && rsp_offset == $past(acc_addr[BANK_AW-1:0]))));

  a_r4_out_of_window: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !in_win) |=> (rsp_err && rsp_cause == 3'd1));

  a_r5_code_bank_no_write: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && in_win && !acc_addr[BANK_AW] && acc_type[1]) |=> (rsp_err && rsp_cause == 3'd2));

  a_r6_data_bank_no_fetch: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && in_win && acc_addr[BANK_AW] && acc_type == 2'd1) |=> (rsp_err && rsp_cause == 3'd3));

  a_r11_go_only_when_clean: assert property (@(posedge clk) disable iff (rst)
    rsp_go |-> (rsp_valid && !rsp_err && rsp_cause == 3'd0));

  a_r11_refused_zeroed: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (!rsp_bank && rsp_offset == '0));

  a_r12_valid_follows: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> rsp_valid);

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (!rsp_valid && !rsp_go && !rsp_err));
endmodule

bind flash_bank_guard fbg_checker #(.ADDR_W(ADDR_W), .BANK_AW(BANK_AW)) chk_i (
  .clk(clk), .rst(rst), .swap_set_en(swap_set_en), .swap_set_val(swap_set_val),
  .swap_q(swap_q), .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_type(acc_type),
  .rsp_valid(rsp_valid), .rsp_go(rsp_go), .rsp_err(rsp_err), .rsp_cause(rsp_cause),
  .rsp_bank(rsp_bank), .rsp_offset(rsp_offset)
);

// File: tb/flash_bank_guard_tb_top.sv
`timescale 1ns/1ps
module flash_bank_guard_tb_top;
  localparam int ADDR_W = 32, BANK_AW = 18, SECTOR_AW = 10;
  localparam int NUM_RXP = 2, NUM_IPP = 2, MST_W = 2;
  localparam int SEC_W = BANK_AW + 1 - SECTOR_AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic swap_set_en = 1'b0, swap_set_val = 1'b0;
  logic acc_valid = 1'b0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic [1:0] acc_type = '0;
  logic [MST_W-1:0] acc_master = '0;
  logic [NUM_RXP-1:0] rxp_en = '0;
  logic [NUM_IPP-1:0] ipp_en = '0;
  logic [NUM_RXP*SEC_W-1:0] rxp_lo, rxp_hi;
  logic [NUM_IPP*SEC_W-1:0] ipp_lo, ipp_hi;
  logic rsp_valid, rsp_go, rsp_err, rsp_bank;
  logic [2:0] rsp_cause;
  logic [BANK_AW-1:0] rsp_offset;
  logic [MST_W-1:0] rsp_master;

  // full-protect: 10..20, and an inverted 100..50 that never hits
  assign rxp_lo = {9'd100, 9'd10};
  assign rxp_hi = {9'd50,  9'd20};
  // hidden-code: 300..310 in the data bank, 15..30 in the code bank
  assign ipp_lo = {9'd15, 9'd300};
  assign ipp_hi = {9'd30, 9'd310};

  always #10 clk = ~clk;

  flash_bank_guard #(.ADDR_W(ADDR_W), .BANK_AW(BANK_AW), .SECTOR_AW(SECTOR_AW),
    .NUM_RXP(NUM_RXP), .NUM_IPP(NUM_IPP), .MST_W(MST_W)) dut_i (
    .clk(clk), .rst(rst), .swap_set_en(swap_set_en), .swap_set_val(swap_set_val),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_type(acc_type), .acc_master(acc_master),
    .rxp_en(rxp_en), .rxp_lo(rxp_lo), .rxp_hi(rxp_hi),
    .ipp_en(ipp_en), .ipp_lo(ipp_lo), .ipp_hi(ipp_hi),
    .rsp_valid(rsp_valid), .rsp_go(rsp_go), .rsp_err(rsp_err), .rsp_cause(rsp_cause),
    .rsp_bank(rsp_bank), .rsp_offset(rsp_offset), .rsp_master(rsp_master)
  );

  int n_cmp = 0, n_bad = 0;
  bit swap_model = 1'b0;
  bit done = 1'b0;

  function automatic int exp_cause(logic [31:0] a, int t);
    int sec;
    bit lb, rx, ip;
    if (a >= 32'h0008_0000) return 1;
    lb  = a[18];
    sec = int'(a >> 10);
    if (!lb && t >= 2) return 2;
    if (lb && t == 1) return 3;
    rx = rxp_en[0] && sec >= 10 && sec <= 20;
    ip = (ipp_en[0] && sec >= 300 && sec <= 310) || (ipp_en[1] && sec >= 15 && sec <= 30);
    if (rx && t <= 1) return 4;
    if (ip && t == 0) return 5;
    return 0;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one request, compare the whole response one cycle later
  task automatic access(input logic [31:0] a, input int t, input int m, input string tag,
                        input bit swap_now = 1'b0, input bit swap_v = 1'b0);
    int ec;
    bit eg, eb;
    logic [BANK_AW-1:0] eo;
    logic [31:0] act, exp;
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_type = t[1:0]; acc_master = m[1:0];
    swap_set_en = swap_now; swap_set_val = swap_v;
    @(posedge clk); #1;
    acc_valid = 1'b0; swap_set_en = 1'b0;
    ec = exp_cause(a, t);
    eg = (ec == 0);
    eb = eg ? (a[18] ^ swap_model) : 1'b0;
    eo = eg ? a[17:0] : '0;
    if (swap_now) swap_model = swap_v;
    act = {rsp_valid, rsp_go, rsp_err, rsp_cause, rsp_bank, rsp_offset, rsp_master};
    exp = {1'b1, eg, !eg, 3'(ec), eb, eo, 2'(m)};
    check(act == exp, tag, act, exp);
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    @(posedge clk); #1;
    check(!rsp_valid && !rsp_go && !rsp_err, tag, {rsp_valid, rsp_go, rsp_err}, 0);
  endtask

  task automatic set_swap(input bit v);
    @(negedge clk); swap_set_en = 1'b1; swap_set_val = v;
    @(posedge clk); #1; swap_set_en = 1'b0; swap_model = v;
  endtask

  function automatic string tag_of(int c, int sec);
    if (c == 4 && sec >= 15) return "R9 overlap";
    case (c)
      0: return "R2 map";
      1: return "R4 range";
      2: return "R5 code-bank write";
      3: return "R6 data-bank fetch";
      4: return "R7 full-protect";
      default: return "R8 hidden-code";
    endcase
  endfunction

  task automatic sweep();
    for (int t = 0; t < 4; t++) begin
      for (int sec = 0; sec < 512; sec++) begin
        logic [31:0] a;
        a = 32'(sec * 1024 + ((sec * 37 + t * 5) % 1024));
        access(a, t, sec % 3, tag_of(exp_cause(a, t), sec));
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!rsp_valid && !rsp_go, "R1 in reset", {rsp_valid, rsp_go}, 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check(!rsp_valid && !rsp_go, "R1 after reset", {rsp_valid, rsp_go}, 0);
    access(32'h0000_0100, 1, 0, "R1 boot fetch in bank0");

    // regions on, both swap settings
    rxp_en = 2'b11; ipp_en = 2'b11;
    for (int s = 0; s < 2; s++) begin
      set_swap(s[0]);
      sweep();
    end
    // regions off separates bank rules from region rules (R7 disable)
    rxp_en = '0; ipp_en = '0;
    for (int s = 0; s < 2; s++) begin
      set_swap(s[0]);
      sweep();
    end
    rxp_en = 2'b11; ipp_en = 2'b11;

    // R4 out-of-window addresses, all types
    for (int t = 0; t < 4; t++) begin
      access(32'h0008_0000, t, 0, "R4 range edge");
      access(32'hFFFF_FFFF, t, 1, "R4 range top");
      access(32'h0010_0400, t, 2, "R4 range high bit");
    end
    access(32'h0007_FFFF, 0, 0, "R2 last byte in window");

    // R3 swap write and access at the same edge
    set_swap(1'b0);
    access(32'h0006_4010, 0, 0, "R3 same-edge old swap", 1'b1, 1'b1);
    access(32'h0006_4010, 0, 0, "R3 new swap next cycle");
    access(32'h0000_0040, 1, 0, "R3 code window follows swap");

    // R10 all masters, same decisions
    for (int m = 0; m < 3; m++) begin
      access(32'h0000_5000, 0, m, "R10 master full-protect read");
      access(32'h0000_7000, 1, m, "R10 master hidden fetch");
      access(32'h0004_2000, 2, m, "R10 master program");
    end

    // R12 idle cycles
    idle_check("R12 idle after access");
    idle_check("R12 idle twice");

    // R1 reset clears a set swap bit
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk); rst = 1'b0; swap_model = 1'b0;
    @(posedge clk); #1;
    check(!rsp_valid, "R1 after second reset", rsp_valid, 0);
    access(32'h0000_0200, 1, 0, "R1 swap cleared");
    access(32'h0004_0200, 2, 0, "R1 bank1 writable after reset");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule